// File: doc/BRIEF.md
# Fault-Only-First Vector Load Sequencer

This block carries out one unit-stride vector load. Given a base address and a requested vector length, it reads consecutive elements through a single-outstanding request/response memory port. Each response may carry an access-fault flag. Returned words are stored in an element buffer, and a read port on that buffer lets the rest of the datapath collect them.

A fault on any element after the first does not raise an exception. The sequencer stops issuing requests and reports a shortened vector length equal to the number of elements that loaded cleanly. Later vector operations therefore see only valid data. A fault on the very first element is different: it raises a trap request that carries the faulting address, and the length is left as requested. An optional early-stop mode ends the sequence when the next element would begin a new page, and shortens the length to match.

Each run ends with a one-cycle done pulse and a final length that holds until the next run. A new request is accepted only while the sequencer is idle.

Top module: `ffload_seq`

## Requirements
- R1: After reset, busy, done, trap_req and mem_req_valid are 0, vl_out is 0 and every buffer entry reads 0.
- R2: Element i is requested at base_addr + i*ELEM_BYTES. A request is a single-cycle pulse, and the next request is issued only after the response to the previous one.
- R3: With no fault and early stop not triggered, all requested elements are written to buffer entries 0..VL-1, done pulses with vl_out = VL and trap_req = 0. A vl_in above MAX_VL is clamped to MAX_VL.
- R4: A fault on element k with k > 0 ends the run with no further requests. vl_out becomes k (never 0), trap_req stays 0, and entries 0..k-1 hold the loaded data.
- R5: A fault on element 0 pulses trap_req together with done. trap_addr equals the base address, and vl_out equals the requested (clamped) VL.
- R6: Buffer entries at or above the final length keep the contents they held before the run.
- R7: With page_stop_en = 1, after element i loads, if i+1 < VL and the address of element i+1 is a multiple of PAGE_BYTES, the run ends with vl_out = i+1. With page_stop_en = 0 the run crosses pages.
- R8: A start with vl_in = 0 issues no request and pulses done on the next cycle with vl_out = 0.
- R9: start is ignored while busy. Its base and length do not alter the run in progress.
- R10: done is a single-cycle pulse. busy is high while a run is in progress and low once done is seen. vl_out holds its value after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| vl_in | input | VL_W | Requested vector length |
| page_stop_en | input | 1 | Enable ending at a page boundary |
| busy | output | 1 | Run in progress |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | ADDR_W | Read request address |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_data | input | DATA_W | Response data |
| mem_rsp_fault | input | 1 | Response reports an access fault |
| done | output | 1 | Run finished (one cycle) |
| vl_out | output | VL_W | Final vector length |
| trap_req | output | 1 | First-element fault trap request (with done) |
| trap_addr | output | ADDR_W | Address of the faulting first element |
| rd_idx | input | IDX_W | Buffer read index |
| rd_data | output | DATA_W | Buffer read data |

## Verification
The bench sweeps every fault position, including no fault, for every length from 0 up to one beyond the buffer depth. It does this for bases that sit three elements and seven elements before a page edge as well as for a page-aligned base, with early stop both off and on.

Several specific failures would show up in this sweep:
- A sequencer that traps on late faults, or reports the fault index plus one, gives the wrong length.
- One that keeps requesting after a fault gives the wrong request count.
- One that writes the faulting or later elements overwrites entries that a previous run filled, and the bench detects this as an R6 violation.
- A fault on element zero must leave the length untouched and report the base address.
- An off-by-one in the page test would stop one element early or late.
- A start pulse while busy that restarts the run would change the addresses that the bench sees.

// File: rtl/ffload_pkg.sv
package ffload_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // Outcome of one returned element
    typedef struct packed {
        logic stop;    // no further requests
        logic trap;    // fault on the first element
        logic shrink;  // fault on a later element
        logic keep;    // data is valid and stored
    } step_verdict_t;

    function automatic step_verdict_t judge_step(
        input logic faulted,
        input logic first_elem,
        input logic last_elem,
        input logic at_edge,
        input logic edge_stop_en
    );
        step_verdict_t v;
        v.trap   = faulted & first_elem;
        v.shrink = faulted & ~first_elem;
        v.keep   = ~faulted;
        v.stop   = faulted | last_elem | (at_edge & edge_stop_en);
        return v;
    endfunction

endpackage

// File: rtl/ffl_addr_gen.sv
module ffl_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 4,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              next_is_edge
);
    localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(ELEM_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

    logic [ADDR_W-1:0] next_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
        end else if (load) begin
            cur_addr <= base;
        end else if (step) begin
            cur_addr <= next_addr;
        end
    end

    assign next_addr    = cur_addr + STRIDE;
    assign next_is_edge = ((next_addr & PAGE_MASK) == '0);

endmodule

// File: rtl/ffl_elem_buf.sv
module ffl_elem_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slots[rd_idx];

endmodule

// File: rtl/ffl_ctrl.sv
module ffl_ctrl
    import ffload_pkg::*;
#(
    parameter int MAX_VL = 8,
    parameter int VL_W   = 4,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VL_W-1:0]  vl_in,
    input  logic             page_stop_en,
    input  logic             rsp_valid,
    input  logic             rsp_fault,
    input  logic             next_is_edge,
    output logic             busy,
    output logic             req_valid,
    output logic             load_base,
    output logic             step_elem,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_idx,
    output logic             trap_fire,
    output logic             done,
    output logic [VL_W-1:0]  vl_out,
    output logic             trap_req
);
    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);
    localparam logic [VL_W-1:0] ONE    = VL_W'(1);

    seq_state_e     state;
    logic [VL_W-1:0] cnt;
    logic [VL_W-1:0] vl_req;
    logic            edge_stop_q;
    logic            done_q;
    logic            trap_q;
    logic [VL_W-1:0] vl_out_q;

    logic [VL_W-1:0] vl_clamped;
    logic            rsp_take;
    step_verdict_t   verdict;
    logic [VL_W-1:0] final_vl;

    assign vl_clamped = (vl_in > VL_CAP) ? VL_CAP : vl_in;
    assign rsp_take   = (state == SEQ_WAIT) && rsp_valid;
    assign verdict    = judge_step(rsp_fault, (cnt == '0), ((cnt + ONE) == vl_req),
                                   next_is_edge, edge_stop_q);
    assign final_vl   = verdict.trap   ? vl_req :
                        verdict.shrink ? cnt    : (cnt + ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            cnt         <= '0;
            vl_req      <= '0;
            edge_stop_q <= 1'b0;
            done_q      <= 1'b0;
            trap_q      <= 1'b0;
            vl_out_q    <= '0;
        end else begin
            done_q <= 1'b0;
            trap_q <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        if (vl_clamped == '0) begin
                            done_q   <= 1'b1;
                            vl_out_q <= '0;
                        end else begin
                            state       <= SEQ_ISSUE;
                            cnt         <= '0;
                            vl_req      <= vl_clamped;
                            edge_stop_q <= page_stop_en;
                        end
                    end
                end
                SEQ_ISSUE: begin
                    state <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (rsp_valid) begin
                        if (verdict.stop) begin
                            state    <= SEQ_IDLE;
                            done_q   <= 1'b1;
                            vl_out_q <= final_vl;
                            trap_q   <= verdict.trap;
                        end else begin
                            cnt   <= cnt + ONE;
                            state <= SEQ_ISSUE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy      = (state != SEQ_IDLE);
    assign req_valid = (state == SEQ_ISSUE);
    assign load_base = (state == SEQ_IDLE) && start && (vl_clamped != '0);
    assign step_elem = rsp_take && !verdict.stop;
    assign buf_we    = rsp_take && verdict.keep;
    assign buf_idx   = cnt[IDX_W-1:0];
    assign trap_fire = rsp_take && verdict.trap;
    assign done      = done_q;
    assign vl_out    = vl_out_q;
    assign trap_req  = trap_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R10

    AST_SHRINK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_take && rsp_fault && cnt != '0) |=> (done_q && vl_out_q != '0 && !trap_q)); // R4

    AST_TRAP_KEEPS_VL: assert property (@(posedge clk) disable iff (rst)
        trap_q |-> (vl_out_q == vl_req && done_q)); // R5

    AST_WRITE_BELOW_VL: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (cnt < vl_req)); // R6

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (vl_req == $past(vl_req))); // R9

endmodule

// File: rtl/ffload_seq.sv
module ffload_seq #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int ELEM_BYTES = 4,
    parameter int MAX_VL     = 8,
    parameter int PAGE_BYTES = 4096,
    localparam int VL_W      = $clog2(MAX_VL + 1),
    localparam int IDX_W     = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [VL_W-1:0]   vl_in,
    input  logic              page_stop_en,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_fault,
    output logic              done,
    output logic [VL_W-1:0]   vl_out,
    output logic              trap_req,
    output logic [ADDR_W-1:0] trap_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic              load_base;
    logic              step_elem;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_idx;
    logic              trap_fire;
    logic              next_is_edge;
    logic [ADDR_W-1:0] cur_addr;

    ffl_ctrl #(
        .MAX_VL (MAX_VL),
        .VL_W   (VL_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .vl_in        (vl_in),
        .page_stop_en (page_stop_en),
        .rsp_valid    (mem_rsp_valid),
        .rsp_fault    (mem_rsp_fault),
        .next_is_edge (next_is_edge),
        .busy         (busy),
        .req_valid    (mem_req_valid),
        .load_base    (load_base),
        .step_elem    (step_elem),
        .buf_we       (buf_we),
        .buf_idx      (buf_idx),
        .trap_fire    (trap_fire),
        .done         (done),
        .vl_out       (vl_out),
        .trap_req     (trap_req)
    );

    ffl_addr_gen #(
        .ADDR_W     (ADDR_W),
        .ELEM_BYTES (ELEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_addr (
        .clk          (clk),
        .rst          (rst),
        .load         (load_base),
        .base         (base_addr),
        .step         (step_elem),
        .cur_addr     (cur_addr),
        .next_is_edge (next_is_edge)
    );

    ffl_elem_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_VL),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_we),
        .wr_idx  (buf_idx),
        .wr_data (mem_rsp_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign mem_req_addr = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_addr <= '0;
        end else if (trap_fire) begin
            trap_addr <= cur_addr;
        end
    end

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid); // R2

    AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && !busy) |-> !mem_req_valid); // R4

endmodule

// File: tb/ffload_seq_test.sv
module ffload_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_VL     = 8;
    localparam int PAGE       = 64;
    localparam int EB         = 4;
    localparam int VL_W       = 4;
    localparam int IDX_W      = 3;

    logic              clk;
    logic              rst;
    logic              start;
    logic [31:0]       base_addr;
    logic [VL_W-1:0]   vl_in;
    logic              page_stop_en;
    logic              busy;
    logic              mem_req_valid;
    logic [31:0]       mem_req_addr;
    logic              mem_rsp_valid;
    logic [31:0]       mem_rsp_data;
    logic              mem_rsp_fault;
    logic              done;
    logic [VL_W-1:0]   vl_out;
    logic              trap_req;
    logic [31:0]       trap_addr;
    logic [IDX_W-1:0]  rd_idx;
    logic [31:0]       rd_data;

    ffload_seq #(
        .ADDR_W(32), .DATA_W(32), .ELEM_BYTES(EB), .MAX_VL(MAX_VL), .PAGE_BYTES(PAGE)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .vl_in(vl_in),
        .page_stop_en(page_stop_en), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault), .done(done),
        .vl_out(vl_out), .trap_req(trap_req), .trap_addr(trap_addr),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int fails = 0;
    int salt  = 1;
    logic [31:0] shadow [MAX_VL];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] resp_word(input logic [31:0] a, input int s);
        return a * 32'd3 + 32'(s);
    endfunction

    task automatic run_load(input logic [31:0] base, input int vl, input bit pstop,
                            input int fidx, input int lat, input bit poke);
        int ev, exp_vl, exp_reqs, written, k, guard;
        bit exp_trap, got, saw_trap;
        string tag;
        logic [31:0] a, trap_a;
        logic [VL_W-1:0] vl_seen;
        ev = (vl > MAX_VL) ? MAX_VL : vl;
        exp_vl = ev; exp_reqs = 0; written = 0; exp_trap = 0;
        tag = (ev == 0) ? "R8" : "R3";
        for (int i = 0; i < ev; i++) begin
            exp_reqs = i + 1;
            if (i == fidx) begin
                if (i == 0) begin exp_trap = 1; tag = "R5"; end
                else begin exp_vl = i; tag = "R4"; end
                break;
            end
            written = i + 1;
            if (i + 1 == ev) break;
            if (pstop && (((base + 32'(i + 1) * EB) % PAGE) == 0)) begin
                exp_vl = i + 1; tag = "R7"; break;
            end
        end
        if (poke) tag = "R9";

        @(negedge clk);
        base_addr = base; vl_in = VL_W'(vl); page_stop_en = pstop; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; guard = 0; got = 0; saw_trap = 0; vl_seen = '0; trap_a = '0;
        while (!got && guard < 400) begin
            if (done) begin
                got = 1; saw_trap = trap_req; vl_seen = vl_out; trap_a = trap_addr;
            end else if (mem_req_valid) begin
                chk(busy == 1'b1, "R10", "busy during request", busy, 1);
                chk(mem_req_addr == base + 32'(k) * EB, "R2", "request address",
                    mem_req_addr, base + 32'(k) * EB);
                a = mem_req_addr;
                for (int w = 0; w < lat; w++) begin
                    start = poke && (k == 0) && (w == 0);
                    if (start) begin vl_in = VL_W'(1); base_addr = 32'h0F00; end
                    @(negedge clk); guard++;
                end
                start = 1'b0;
                mem_rsp_valid = 1'b1; mem_rsp_fault = (k == fidx);
                mem_rsp_data = resp_word(a, salt);
                k++;
                @(negedge clk); guard++;
                mem_rsp_valid = 1'b0; mem_rsp_fault = 1'b0;
            end else begin
                @(negedge clk); guard++;
            end
        end
        if (!got) begin
            chk(0, tag, "run did not finish", guard, 0);
        end else begin
            chk(vl_seen == VL_W'(exp_vl), tag, "final length", vl_seen, exp_vl);
            chk(saw_trap == exp_trap, tag, "trap flag", saw_trap, exp_trap);
            if (exp_trap) chk(trap_a == base, "R5", "trap address", trap_a, base);
            chk(k == exp_reqs, (tag == "R3") ? "R2" : tag, "request count", k, exp_reqs);
        end
        for (int i = 0; i < written; i++) shadow[i] = resp_word(base + 32'(i) * EB, salt);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done single pulse", done, 0);
        chk(busy == 1'b0, "R10", "idle after done", busy, 0);
        chk(vl_out == vl_seen, "R10", "length held", vl_out, vl_seen);
        for (int j = 0; j < MAX_VL; j++) begin
            rd_idx = IDX_W'(j);
            #1;
            chk(rd_data == shadow[j], (j < written) ? "R3" : "R6", "buffer entry",
                rd_data, shadow[j]);
        end
        salt++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] bases [3];
        bases[0] = 32'h0000_1034;
        bases[1] = 32'h0000_1024;
        bases[2] = 32'h0000_1040;
        for (int i = 0; i < MAX_VL; i++) shadow[i] = '0;
        rst = 1'b1; start = 1'b0; base_addr = '0; vl_in = '0; page_stop_en = 1'b0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_fault = 1'b0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(trap_req == 1'b0, "R1", "trap after reset", trap_req, 0);
        chk(mem_req_valid == 1'b0, "R1", "request after reset", mem_req_valid, 0);
        chk(vl_out == '0, "R1", "length after reset", vl_out, 0);
        for (int j = 0; j < MAX_VL; j++) begin
            rd_idx = IDX_W'(j);
            #1;
            chk(rd_data == 32'd0, "R1", "buffer after reset", rd_data, 0);
        end

        for (int b = 0; b < 3; b++) begin
            for (int p = 0; p < 2; p++) begin
                for (int vl = 0; vl <= MAX_VL + 1; vl++) begin
                    for (int f = -1; f < ((vl > MAX_VL) ? MAX_VL : vl); f++) begin
                        run_load(bases[b], vl, p[0], f, 1 + (salt % 2), 1'b0);
                    end
                end
            end
        end

        run_load(32'h0000_3000, 5, 1'b0, -1, 3, 1'b1);
        run_load(32'h0000_3100, 12, 1'b0, 6, 2, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule